// File: doc/BRIEF.md
# Three-Axis Quadrature Decoder Hub

The hub turns up to three pairs of incremental-encoder signals into signed 16-bit position counts. Each axis picks its A/B pair from a shared bus of input pins. All three axes sample their inputs on a common enable, which comes from a programmable divider with an optional extra halving stage. An axis counts in one of two ways. In quadrature mode it counts up or down by the phase order of A and B. In edge mode it counts every change on either line.

Every counted step is also an event. Events from all axes are totalled in an 8-bit counter. When the total reaches a programmed threshold plus one, the hub latches a pending interrupt flag and the total starts again from zero. The interrupt pin is this flag gated by an enable bit. Software reaches everything through a 16-bit register interface. A write is one strobe carrying an address and data. A read is combinational from a separate read address.

Top module: `axis_decoder_hub`

## Requirements
- R1: After reset every register reads 0, all three axes are disabled and `irq` is low.
- R2: An axis samples its A/B inputs once every (D+1)·(P+1) clock cycles. D is the divider field at address 1 bits [9:0] and P is the halving bit at address 1 bit 15.
- R3: In quadrature mode the phase order {A,B} = 00→10→11→01→00 adds 1 per step and the reverse order subtracts 1. The count is 16-bit two's complement and is read at addresses 3, 4 and 5 for axes X, Y and Z.
- R4: In quadrature mode, a sample where A and B both changed leaves the count unchanged and produces no event.
- R5: In edge mode (address 2 bits 9, 10 and 11 for X, Y and Z), any change of A, B or both adds exactly 1 and produces one event.
- R6: The 3-bit axis selects sit at address 2 bits [2:0] for X, [5:3] for Y and [8:6] for Z. Code k from 1 to 6 takes A from pin 2k−2 and B from pin 2k−1, and pins outside that pair have no effect. Codes 0 and 7 disable the axis, which then reads 0 and keeps its count at 0.
- R7: After an axis is enabled or its select code changes, its first sample only records the input phase and does not count. A count built up earlier is kept across a change from one enabled code to another.
- R8: The event total at address 6 adds every event of a cycle, counting one event per axis. While an interrupt is pending, it saturates at 255.
- R9: Writing address 0 with bit 1 set clears the event total to 0. Bit 1 always reads back as 0.
- R10: When no interrupt is pending and the event total would reach T+1, the pending flag sets and the total becomes 0. T is address 0 bits [15:8].
- R11: The pending flag reads at address 0 bit 2, and writing 1 to that bit clears it. `irq` equals the pending flag ANDed with the enable at address 0 bit 0.
- R12: Writes to addresses 3 to 7 have no effect, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wr_addr | input | 3 | Register address for the write |
| reg_wdata | input | 16 | Write data |
| reg_rd_addr | input | 3 | Register address for the read |
| reg_rdata | output | 16 | Read data, combinational from `reg_rd_addr` |
| pins | input | 12 | Asynchronous encoder input pins |
| irq | output | 1 | Interrupt request |

## Verification
Some properties hold on every cycle, and the assertions watch them throughout. The interrupt pin never rises while masked, and a disabled axis holds a zero count. Counts move only on a sampling enable, and the halving stage never gives two enables in a row. The event total only steps up by at most one per axis, or drops to zero, and it is zero whenever the pending flag rises. Other behaviour needs scenarios from the bench: count direction, ignoring both-line changes, the priming sample, pin routing, the exact threshold-plus-one count, saturation, and the measured sampling period.

// File: rtl/axd_pkg.sv
package axd_pkg;

    localparam int NUM_AXES = 3;
    localparam int SEL_W    = 3;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int EVT_W    = 8;
    localparam int THR_W    = 8;

    // control-word bit positions
    localparam int CW_IRQ_EN = 0;
    localparam int CW_CLEAR  = 1;
    localparam int CW_ACK    = 2;
    localparam int CW_THR_LO = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_TIMING = 3'd1,
        A_ROUTE  = 3'd2,
        A_CNT_X  = 3'd3,
        A_CNT_Y  = 3'd4,
        A_CNT_Z  = 3'd5,
        A_EVENTS = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             irq_en;
    } ctrl_t;

    typedef struct packed {
        logic [NUM_AXES-1:0]            edge_mode;
        logic [NUM_AXES-1:0][SEL_W-1:0] sel;
    } route_t;

    typedef enum logic [1:0] {
        STEP_NONE,
        STEP_UP,
        STEP_DOWN
    } step_e;

    // Gray position of the A/B pair along the forward rotation
    function automatic logic [1:0] phase_of(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic step_e classify(input logic [1:0] prev_ph, input logic [1:0] cur_ph);
        logic [1:0] diff;
        diff = cur_ph - prev_ph;
        case (diff)
            2'd1:    return STEP_UP;
            2'd3:    return STEP_DOWN;
            default: return STEP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/axd_tick_gen.sv
module axd_tick_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             halve,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             half_q;
    logic             hit;

    assign hit  = (cnt_q >= div);
    assign tick = hit && (!halve || half_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else begin
            if (hit) begin
                cnt_q  <= '0;
                half_q <= ~half_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/axd_pin_route.sv
module axd_pin_route
    import axd_pkg::*;
#(
    parameter int NUM_PINS = 12
) (
    input  logic [NUM_PINS-1:0] pins,
    input  logic [SEL_W-1:0]    sel,
    output logic                pin_a,
    output logic                pin_b,
    output logic                on
);

    localparam int NUM_PAIRS = NUM_PINS / 2;
    localparam int TOP_CODE  = (2 ** SEL_W) - 1;
    localparam int MAX_CODE  = (NUM_PAIRS < TOP_CODE) ? NUM_PAIRS : TOP_CODE;

    always_comb begin
        pin_a = 1'b0;
        pin_b = 1'b0;
        on    = 1'b0;
        for (int k = 1; k <= MAX_CODE; k++) begin
            if (sel == SEL_W'(k)) begin
                pin_a = pins[2*k-2];
                pin_b = pins[2*k-1];
                on    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/axd_channel.sv
module axd_channel
    import axd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             on,
    input  logic [SEL_W-1:0] sel,
    input  logic             edge_mode,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic [CNT_W-1:0] count,
    output logic             evt
);

    logic [1:0]       prev_q;
    logic             primed_q;
    logic [SEL_W-1:0] sel_q;
    logic [1:0]       cur_ph;
    step_e            step;
    logic             moved;

    always_comb begin
        cur_ph = phase_of(pin_a, pin_b);
        step   = classify(prev_q, cur_ph);
        moved  = (cur_ph != prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            evt      <= 1'b0;
            prev_q   <= '0;
            primed_q <= 1'b0;
            sel_q    <= '0;
        end else begin
            evt   <= 1'b0;
            sel_q <= sel;
            if (!on) begin
                count    <= '0;
                primed_q <= 1'b0;
            end else if (sel != sel_q) begin
                primed_q <= 1'b0;
            end else if (tick) begin
                prev_q <= cur_ph;
                if (!primed_q) begin
                    primed_q <= 1'b1;
                end else if (edge_mode) begin
                    if (moved) begin
                        count <= count + 1'b1;
                        evt   <= 1'b1;
                    end
                end else begin
                    case (step)
                        STEP_UP: begin
                            count <= count + 1'b1;
                            evt   <= 1'b1;
                        end
                        STEP_DOWN: begin
                            count <= count - 1'b1;
                            evt   <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/axd_evt_irq.sv
module axd_evt_irq
    import axd_pkg::*;
#(
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               clr,
    input  logic               ack,
    input  logic [THR_W-1:0]   thr,
    output logic [EVT_W-1:0]   total,
    output logic               status
);

    localparam int SUM_W   = EVT_W + $clog2(NUM_EVT + 1) + 1;
    localparam int EVT_MAX = (2 ** EVT_W) - 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] goal;
    logic [EVT_W-1:0] sat;
    logic             reach;

    always_comb begin
        sum   = SUM_W'(total) + SUM_W'($countones(evt));
        goal  = SUM_W'(thr) + 1'b1;
        reach = !status && (sum >= goal);
        sat   = (sum > SUM_W'(EVT_MAX)) ? EVT_W'(EVT_MAX) : sum[EVT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total  <= '0;
            status <= 1'b0;
        end else begin
            if (clr || reach) begin
                total <= '0;
            end else begin
                total <= sat;
            end
            if (reach && !clr) begin
                status <= 1'b1;
            end else if (ack) begin
                status <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/axis_decoder_hub.sv
module axis_decoder_hub
    import axd_pkg::*;
#(
    parameter int NUM_PINS    = 12,
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_wr_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [ADDR_W-1:0]   reg_rd_addr,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pins,
    output logic                irq
);

    localparam int ROUTE_W = $bits(route_t);

    ctrl_t            ctrl_q;
    route_t           route_q;
    logic [DIV_W-1:0] div_q;
    logic             pre_q;

    logic wr_ctrl, wr_timing, wr_route;
    logic evt_clr, irq_ack;

    logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0]                  pins_s;

    logic                               tick_w;
    logic [NUM_AXES-1:0]                on_w;
    logic [NUM_AXES-1:0]                evt_w;
    logic [NUM_AXES-1:0][CNT_W-1:0]     cnt_w;
    logic [NUM_AXES-1:0][REG_W-1:0]     cnt_ext;
    logic [EVT_W-1:0]                   evt_cnt_w;
    logic                               status_w;
    logic                               irq_en_w;

    // register writes
    assign wr_ctrl   = reg_wr && (reg_wr_addr == A_CTRL);
    assign wr_timing = reg_wr && (reg_wr_addr == A_TIMING);
    assign wr_route  = reg_wr && (reg_wr_addr == A_ROUTE);
    assign evt_clr   = wr_ctrl && reg_wdata[CW_CLEAR];
    assign irq_ack   = wr_ctrl && reg_wdata[CW_ACK];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            route_q <= '0;
            div_q   <= '0;
            pre_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.irq_en <= reg_wdata[CW_IRQ_EN];
                ctrl_q.thr    <= reg_wdata[CW_THR_LO +: THR_W];
            end
            if (wr_timing) begin
                div_q <= reg_wdata[DIV_W-1:0];
                pre_q <= reg_wdata[REG_W-1];
            end
            if (wr_route) begin
                route_q <= route_t'(reg_wdata[ROUTE_W-1:0]);
            end
        end
    end

    // input synchronizer
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= pins;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end
    assign pins_s = sync_q[SYNC_STAGES-1];

    axd_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .div   (div_q),
        .halve (pre_q),
        .tick  (tick_w)
    );

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
        logic pa, pb;

        axd_pin_route #(.NUM_PINS(NUM_PINS)) u_route (
            .pins  (pins_s),
            .sel   (route_q.sel[ax]),
            .pin_a (pa),
            .pin_b (pb),
            .on    (on_w[ax])
        );

        axd_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick_w),
            .on        (on_w[ax]),
            .sel       (route_q.sel[ax]),
            .edge_mode (route_q.edge_mode[ax]),
            .pin_a     (pa),
            .pin_b     (pb),
            .count     (cnt_w[ax]),
            .evt       (evt_w[ax])
        );

        always_comb begin
            cnt_ext[ax]              = {REG_W{cnt_w[ax][CNT_W-1]}};
            cnt_ext[ax][CNT_W-1:0]   = cnt_w[ax];
            if (!on_w[ax]) begin
                cnt_ext[ax] = '0;
            end
        end
    end

    axd_evt_irq #(.NUM_EVT(NUM_AXES)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_w),
        .clr    (evt_clr),
        .ack    (irq_ack),
        .thr    (ctrl_q.thr),
        .total  (evt_cnt_w),
        .status (status_w)
    );

    assign irq_en_w = ctrl_q.irq_en;
    assign irq      = status_w && irq_en_w;

    // register reads
    always_comb begin
        reg_rdata = '0;
        case (reg_rd_addr)
            A_CTRL: begin
                reg_rdata[CW_IRQ_EN]              = ctrl_q.irq_en;
                reg_rdata[CW_ACK]                 = status_w;
                reg_rdata[CW_THR_LO +: THR_W]     = ctrl_q.thr;
            end
            A_TIMING: begin
                reg_rdata[DIV_W-1:0] = div_q;
                reg_rdata[REG_W-1]   = pre_q;
            end
            A_ROUTE:  reg_rdata[ROUTE_W-1:0] = route_q;
            A_CNT_X:  reg_rdata = cnt_ext[0];
            A_CNT_Y:  reg_rdata = cnt_ext[1];
            A_CNT_Z:  reg_rdata = cnt_ext[2];
            A_EVENTS: reg_rdata[EVT_W-1:0] = evt_cnt_w;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/axd_hub_chk.sv
module axd_hub_chk
    import axd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           irq,
    input logic                           irq_en,
    input logic                           status,
    input logic [EVT_W-1:0]               evt_cnt,
    input logic                           tick,
    input logic                           pre,
    input logic [NUM_AXES-1:0]            on,
    input logic [NUM_AXES-1:0][CNT_W-1:0] cnt
);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R10
    evt_restart_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> (evt_cnt == '0));

    // R8
    evt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (evt_cnt == '0) ||
                 ((evt_cnt >= $past(evt_cnt)) &&
                  ((evt_cnt - $past(evt_cnt)) <= EVT_W'(NUM_AXES))));

    // R2
    halve_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pre && tick) ##1 pre |-> !tick);

    for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_ax
        // R6
        off_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !on[ax] |=> (cnt[ax] == '0));

        // R2
        hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
            (!tick && on[ax]) |=> $stable(cnt[ax]));
    end

endmodule

bind axis_decoder_hub axd_hub_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq     (irq),
    .irq_en  (irq_en_w),
    .status  (status_w),
    .evt_cnt (evt_cnt_w),
    .tick    (tick_w),
    .pre     (pre_q),
    .on      (on_w),
    .cnt     (cnt_w)
);

// File: tb/sim_axis_decoder_hub.sv
module sim_axis_decoder_hub;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_wr_addr;
    logic [15:0] reg_wdata;
    logic [2:0]  reg_rd_addr = 3'd3;
    logic [15:0] reg_rdata;
    logic [11:0] pins;
    logic        irq;

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit timed_out = 1'b0;

    // kind 0: register read, 1: irq pin, 2: value measured by driver
    typedef struct {
        int          kind;
        logic [2:0]  addr;
        int          exp;
        int          act;
        string       tag;
    } item_t;

    item_t sb_q[$];

    axis_decoder_hub u0 (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_wr_addr (reg_wr_addr),
        .reg_wdata   (reg_wdata),
        .reg_rd_addr (reg_rd_addr),
        .reg_rdata   (reg_rdata),
        .pins        (pins),
        .irq         (irq)
    );

    // monitor: sole owner of the counters and of the read address
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                item_t it;
                int    act;
                it = sb_q[0];
                reg_rd_addr = it.addr;
                #1;
                if (it.kind == 0)      act = int'(reg_rdata);
                else if (it.kind == 1) act = int'(irq);
                else                   act = it.act;
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
                void'(sb_q.pop_front());
                reg_rd_addr = 3'd3;
            end else if (done || timed_out) begin
                if (timed_out && !done) begin
                    errors++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
    end

    // ---------------- driver side ----------------
    task automatic drain();
        do @(negedge clk); while (sb_q.size() != 0);
    endtask

    task automatic exp_reg(input logic [2:0] a, input int e, input string tag);
        item_t it;
        it.kind = 0; it.addr = a; it.exp = e; it.act = 0; it.tag = tag;
        sb_q.push_back(it);
        drain();
    endtask

    task automatic exp_irq(input int e, input string tag);
        item_t it;
        it.kind = 1; it.addr = 3'd3; it.exp = e; it.act = 0; it.tag = tag;
        sb_q.push_back(it);
        drain();
    endtask

    task automatic exp_val(input int a, input int e, input string tag);
        item_t it;
        it.kind = 2; it.addr = 3'd3; it.exp = e; it.act = a; it.tag = tag;
        sb_q.push_back(it);
        drain();
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr      = 1'b1;
        reg_wr_addr = a;
        reg_wdata   = d;
        @(negedge clk);
        reg_wr      = 1'b0;
        settle();
    endtask

    function automatic logic [15:0] cw(input bit en, input bit clr, input bit ack, input int thr);
        logic [7:0] t;
        t = 8'(thr);
        return {t, 5'b0, ack, clr, en};
    endfunction

    function automatic logic [15:0] rt(input int sx, input int sy, input int sz,
                                       input bit mx, input bit my, input bit mz);
        logic [2:0] x, y, z;
        x = 3'(sx); y = 3'(sy); z = 3'(sz);
        return {4'b0, mz, my, mx, z, y, x};
    endfunction

    task automatic ab0(input bit a, input bit b);
        pins[0] = a; pins[1] = b;
        settle();
    endtask

    task automatic flip2();
        pins[2] = ~pins[2];
        settle();
    endtask

    task automatic measure(input int expp, input string tag);
        int t1, t2, n;
        logic [15:0] c;
        c = reg_rdata; pins[2] = ~pins[2]; n = 0;
        do begin @(negedge clk); n++; end while (reg_rdata == c && n < 200);
        t1 = cyc;
        c = reg_rdata; pins[2] = ~pins[2]; n = 0;
        do begin @(negedge clk); n++; end while (reg_rdata == c && n < 200);
        t2 = cyc;
        exp_val(t2 - t1, expp, tag);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_wr_addr = '0; reg_wdata = '0; pins = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 7; a++) exp_reg(3'(a), 0, "R1 reset register");
        exp_irq(0, "R1 irq after reset");
        exp_reg(3'd7, 0, "R12 unmapped address");

        // R7 / R3: priming and quadrature direction on pins 0/1
        wr(3'd0, cw(0, 0, 0, 255));
        exp_reg(3'd0, 16'hFF00, "R12 control readback");
        ab0(1, 0);
        wr(3'd2, rt(1, 0, 0, 0, 0, 0));
        exp_reg(3'd3, 0, "R7 first sample does not count");
        ab0(1, 1); ab0(0, 1); ab0(0, 0); ab0(1, 0);
        exp_reg(3'd3, 4, "R3 forward steps");
        ab0(0, 0); ab0(0, 1); ab0(1, 1);
        exp_reg(3'd3, 1, "R3 reverse steps");
        ab0(1, 0); ab0(0, 0); ab0(0, 1);
        exp_reg(3'd3, 16'hFFFE, "R3 negative two's complement");
        exp_reg(3'd6, 10, "R8 event total");

        // R4: both lines change
        ab0(1, 0);
        exp_reg(3'd3, 16'hFFFE, "R4 double change ignored");
        exp_reg(3'd6, 10, "R4 no event on double change");

        // R9: clear
        wr(3'd0, cw(0, 1, 0, 255));
        exp_reg(3'd6, 0, "R9 event total cleared");
        exp_reg(3'd0, 16'hFF00, "R9 clear bit reads 0");

        // R6 / R7: reroute X to pins 6/7, Y to code 7
        wr(3'd2, rt(4, 7, 0, 0, 0, 0));
        exp_reg(3'd3, 16'hFFFE, "R7 count kept over reroute");
        pins[6] = 1'b1; settle();
        exp_reg(3'd3, 16'hFFFF, "R6 code 4 A on pin 6");
        ab0(0, 0);
        exp_reg(3'd3, 16'hFFFF, "R6 old pair has no effect");
        pins[7] = 1'b1; settle();
        exp_reg(3'd3, 0, "R6 code 4 B on pin 7");
        exp_reg(3'd4, 0, "R6 code 7 disabled reads 0");

        // R5: edge mode on Y sharing pins 6/7
        wr(3'd2, rt(4, 4, 0, 0, 1, 0));
        pins[6] = 1'b0; pins[7] = 1'b0; settle();
        exp_reg(3'd4, 1, "R5 double change counts once");
        exp_reg(3'd3, 0, "R4 quadrature axis ignores double change");
        pins[6] = 1'b1; settle();
        exp_reg(3'd4, 2, "R5 single edge counts");
        exp_reg(3'd3, 1, "R3 forward on rerouted axis");

        // R8: three events in one cycle
        wr(3'd2, rt(2, 2, 2, 1, 1, 1));
        wr(3'd0, cw(0, 1, 0, 255));
        flip2();
        exp_reg(3'd6, 3, "R8 simultaneous events summed");
        exp_reg(3'd5, 1, "R6 code 2 routes pins 2/3");

        // R10 / R11: threshold 4 needs 5 events
        wr(3'd2, rt(2, 0, 0, 1, 0, 0));
        wr(3'd0, cw(0, 1, 1, 4));
        for (int i = 0; i < 4; i++) flip2();
        exp_reg(3'd6, 4, "R10 below threshold");
        exp_reg(3'd0, 16'h0400, "R10 not yet pending");
        flip2();
        exp_reg(3'd6, 0, "R10 total restarts");
        exp_reg(3'd0, 16'h0404, "R10 pending after threshold+1");
        exp_irq(0, "R11 masked irq");
        wr(3'd0, cw(1, 0, 0, 4));
        exp_irq(1, "R11 enabled irq");
        wr(3'd0, cw(1, 0, 1, 4));
        exp_irq(0, "R11 write-1 clears pending");
        exp_reg(3'd0, 16'h0401, "R11 status cleared");

        // R8: saturation while pending
        wr(3'd0, cw(0, 1, 1, 0));
        wr(3'd2, rt(2, 2, 2, 1, 1, 1));
        flip2();
        exp_reg(3'd0, 16'h0004, "R10 threshold zero fires");
        for (int i = 0; i < 84; i++) flip2();
        exp_reg(3'd6, 252, "R8 accumulates while pending");
        flip2();
        exp_reg(3'd6, 255, "R8 reaches 255");
        flip2();
        exp_reg(3'd6, 255, "R8 saturates at 255");
        wr(3'd0, cw(0, 1, 1, 0));
        exp_reg(3'd6, 0, "R9 clear after saturation");

        // R6 / R12: disable, then writes to read-only registers
        wr(3'd2, rt(0, 0, 0, 0, 0, 0));
        exp_reg(3'd3, 0, "R6 disabled X reads 0");
        wr(3'd2, rt(2, 0, 0, 1, 0, 0));
        exp_reg(3'd3, 0, "R6 count restarts from 0");
        flip2();
        wr(3'd3, 16'h1234);
        wr(3'd7, 16'hFFFF);
        exp_reg(3'd3, 1, "R12 write to count ignored");
        exp_reg(3'd7, 0, "R12 address 7 stays 0");

        // R2: sampling period
        wr(3'd1, 16'h0003);
        exp_reg(3'd1, 16'h0003, "R12 timing readback");
        measure(4, "R2 period divider 3");
        wr(3'd1, 16'h8004);
        measure(10, "R2 period divider 4 halved");
        wr(3'd1, 16'h0000);

        done = 1'b1;
    end

endmodule